// File: doc/BRIEF.md
# UART Receiver with Sticky Status Flags

This block turns an asynchronous serial line into bytes. It also holds the byte and a set of status flags that a bus master reads through two register addresses. Each bit period lasts sixteen baud ticks. The receiver takes three samples near the middle of each bit and decides the bit by majority vote. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit.

A completed frame is written to the data register and raises the data-full flag. Four error flags sit beside data-full: overrun, noise, framing and parity. An error flag is cleared only by a read of the status address that returns the flag as 1, followed later by a read of the data address. A framing error stops reception until software clears it. If a second frame arrives before the first has been read, the second frame is dropped and the overrun flag is raised.

The frame state machine has five states:
- `ST_IDLE` waits for a low line on a tick.
- `ST_START` checks the start bit.
- `ST_DATA` shifts in the data bits.
- `ST_PARITY` captures the parity bit.
- `ST_STOP` resolves the stop bit and returns to idle.

Its transitions are:
- idle→start on a low sample while reception is not halted.
- start→idle when the voted start bit is high (false start).
- start→data when the voted start bit is low.
- data→parity after the last data bit when parity is enabled.
- data→stop after the last data bit when parity is disabled.
- parity→stop at the end of the parity bit.
- stop→idle after the third stop sample.

Top module: `uart_rx_sticky`

## Requirements
- R1: A bit lasts 16 ticks of `baud_tick`, counted from the tick on which a low line is first seen while idle (tick 0). The bit value is the majority of the line samples taken at ticks 7, 8 and 9. Data bits arrive least significant bit first. A read with `rd_addr`=1 returns the data register. A read with `rd_addr`=0 returns the status byte, in which bit 5 is data-full.
- R2: If a frame completes while data-full is 1, the overrun flag (status bit 3) is set and the new frame is discarded. The data register keeps its unread byte, and no noise, framing or parity flag is set for the discarded frame.
- R3: The noise, framing and parity flags are set only in the same cycle in which data-full is set by an accepted frame.
- R4: The framing flag (status bit 1) is set when the voted stop bit is 0.
- R5: While the framing flag is 1, incoming frames are ignored. The data register, data-full and overrun do not change.
- R6: With `par_en`=1, the parity flag (status bit 0) is set when the received parity bit differs from the XOR of the eight data bits XOR `par_odd`. The value `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. With `par_en`=0, no parity bit is received and the flag is never set.
- R7: An error flag is cleared only by a data read that follows a status read which returned that flag as 1. A data read with no such status read leaves the flag set.
- R8: Any data read clears data-full.
- R9: Suppose overrun is set after the status read that armed a clear. The following data read then clears data-full but leaves overrun set. A further status read followed by a data read clears overrun.
- R10: The noise flag (status bit 2) is set when the three samples of any bit of an accepted frame disagree. The byte is still taken from the majority votes.
- R11: After reset all flags are 0. Status bits 7, 6 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 1 | 0 selects status, 1 selects data |
| rd_data | output | 8 | Read data for the selected register |
| data_full | output | 1 | Unread byte held |
| overrun | output | 1 | Overrun flag |
| noise_err | output | 1 | Noise flag |
| frame_err | output | 1 | Framing flag |
| parity_err | output | 1 | Parity flag |

## Verification
A wrong sample position or a bit counter that is off by one shows up as a corrupted byte. It is visible at the first data read after the frame, about 180 ticks after the start edge.

A faulty clear-arming bit shows up in two ways. Either a flag survives the status-then-data sequence, or it vanishes after a lone data read; either appears on the very next status read.

The overrun corner case and the framing halt are driven directly. In the halt test, a frame sent during the halt must leave the held byte and data-full untouched. Random frames with random errors and random read orders then compare every read against a flag model built from the requirements.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic       noisy;
        logic       bad_stop;
        logic       bad_parity;
        logic [7:0] byte_val;
    } rx_frame_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic split3(input logic [2:0] s);
        return (s != 3'b000) && (s != 3'b111);
    endfunction

endpackage

// File: rtl/uart_rx_frame_fsm.sv
module uart_rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int SAMPLE_MID = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line,
    input  logic      halt,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      frame_done,
    output rx_frame_t frame
);
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(OSR);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] SMP_LO   = CNT_W'(SAMPLE_MID - 1);
    localparam logic [CNT_W-1:0] SMP_HI   = CNT_W'(SAMPLE_MID + 1);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        smp_q;
    logic [DATA_W-1:0] shf_q;
    logic [IDX_W-1:0]  idx_q;
    logic              noise_q, pbit_q;

    logic       go_start, bit_end, stop_end, in_window;
    logic [2:0] smp_now;

    assign go_start  = (state_q == ST_IDLE) && tick && !halt && !line;
    assign bit_end   = tick && (cnt_q == CNT_LAST);
    assign stop_end  = (state_q == ST_STOP) && tick && (cnt_q == SMP_HI);
    assign in_window = (cnt_q >= SMP_LO) && (cnt_q <= SMP_HI);
    assign smp_now   = {smp_q[1:0], line};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go_start) state_d = ST_START;
            ST_START:  if (bit_end) state_d = vote3(smp_q) ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_end && idx_q == IDX_W'(DATA_W - 1))
                           state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (stop_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // bit timing and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            smp_q   <= '0;
            shf_q   <= '0;
            idx_q   <= '0;
            noise_q <= 1'b0;
            pbit_q  <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            cnt_q   <= go_start ? CNT_W'(1) : '0;
            idx_q   <= '0;
            noise_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (in_window) smp_q <= smp_now;
            if (bit_end) begin
                noise_q <= noise_q | split3(smp_q);
                if (state_q == ST_DATA) begin
                    shf_q <= {vote3(smp_q), shf_q[DATA_W-1:1]};
                    idx_q <= idx_q + 1'b1;
                end
                if (state_q == ST_PARITY) pbit_q <= vote3(smp_q);
            end
        end
    end

    // frame result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame      <= '0;
        end else begin
            frame_done <= stop_end;
            if (stop_end) begin
                frame.byte_val   <= shf_q;
                frame.noisy      <= noise_q | split3(smp_now);
                frame.bad_stop   <= !vote3(smp_now);
                frame.bad_parity <= par_en && (pbit_q != ((^shf_q) ^ par_odd));
            end
        end
    end

endmodule

// File: rtl/uart_rx_flag_regs.sv
module uart_rx_flag_regs
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_done,
    input  rx_frame_t  frame,
    input  logic       stat_rd,
    input  logic       data_rd,
    output logic [7:0] data_q,
    output logic       full_q,
    output logic [3:0] err_q
);
    localparam int NERR = 4;

    logic            accept, ovr_evt;
    logic [NERR-1:0] evt, armed_q;

    assign accept  = frame_done && !full_q;
    assign ovr_evt = frame_done && full_q;
    // error vector order: [3] overrun, [2] noise, [1] framing, [0] parity
    assign evt = {ovr_evt,
                  accept && frame.noisy,
                  accept && frame.bad_stop,
                  accept && frame.bad_parity};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (accept) begin
            data_q <= frame.byte_val;
            full_q <= 1'b1;
        end else if (data_rd) begin
            full_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < NERR; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                err_q[i]   <= 1'b0;
                armed_q[i] <= 1'b0;
            end else begin
                if (evt[i])                       err_q[i] <= 1'b1;
                else if (data_rd && armed_q[i])   err_q[i] <= 1'b0;
                if (stat_rd)      armed_q[i] <= err_q[i];
                else if (data_rd) armed_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
    import uart_rx_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int SAMPLE_MID = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       baud_tick,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_stb,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    output logic       data_full,
    output logic       overrun,
    output logic       noise_err,
    output logic       frame_err,
    output logic       parity_err
);
    logic       frame_done;
    rx_frame_t  frame;
    logic [7:0] held_data;
    logic [3:0] err;

    uart_rx_frame_fsm #(.OSR(OSR), .SAMPLE_MID(SAMPLE_MID)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .line       (rx_line),
        .halt       (frame_err),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .frame_done (frame_done),
        .frame      (frame)
    );

    uart_rx_flag_regs flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame      (frame),
        .stat_rd    (rd_stb && !rd_addr),
        .data_rd    (rd_stb && rd_addr),
        .data_q     (held_data),
        .full_q     (data_full),
        .err_q      (err)
    );

    assign overrun    = err[3];
    assign noise_err  = err[2];
    assign frame_err  = err[1];
    assign parity_err = err[0];

    always_comb begin
        rd_data = '0;
        if (rd_addr) begin
            rd_data = held_data;
        end else begin
            rd_data[5]   = data_full;
            rd_data[3:0] = err;
        end
    end

endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       rd_addr,
    input logic       par_en,
    input logic       data_full,
    input logic       overrun,
    input logic       noise_err,
    input logic       frame_err,
    input logic       parity_err,
    input logic [7:0] held_data
);
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(held_data)); // R2

    AST_NOISE_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise_err) |-> $rose(data_full)); // R3

    AST_FRAME_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $rose(data_full)); // R3

    AST_PARITY_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> $rose(data_full)); // R3

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && $past(frame_err)) |-> ($stable(held_data) && !$rose(data_full))); // R5

    AST_PARITY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> $past(par_en)); // R6

    AST_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(overrun) || $fell(noise_err) || $fell(frame_err) || $fell(parity_err))
            |-> $past(rd_stb && rd_addr)); // R7

    AST_FULL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stb && rd_addr && data_full) |-> !data_full); // R8

endmodule

bind uart_rx_sticky uart_rx_sticky_chk chk_i (.*);

// File: tb/uart_rx_sticky_tb_top.sv
module uart_rx_sticky_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       baud_tick = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       data_full, overrun, noise_err, frame_err, parity_err;

    int checks = 0;
    int errors = 0;

    // bench flag model, built from the requirements
    logic       m_full = 0, m_or = 0, m_nf = 0, m_fe = 0, m_pf = 0;
    logic [7:0] m_data = '0;
    logic [3:0] m_arm = '0;

    always #2.5 clk = ~clk;

    uart_rx_sticky dut_i (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
        .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .data_full(data_full), .overrun(overrun),
        .noise_err(noise_err), .frame_err(frame_err), .parity_err(parity_err)
    );

    function automatic logic [7:0] exp_status();
        return {2'b00, m_full, 1'b0, m_or, m_nf, m_fe, m_pf};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic one_tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic model_frame(input logic [7:0] d, input logic nf, input logic fe, input logic pf);
        if (m_fe) return;
        if (m_full) begin
            m_or = 1'b1;
        end else begin
            m_full = 1'b1;
            m_data = d;
            if (nf) m_nf = 1'b1;
            if (fe) m_fe = 1'b1;
            if (pf) m_pf = 1'b1;
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pe, input logic po,
                              input logic bad_par, input logic bad_stop, input int noise_bit);
        logic [11:0] bits;
        int nb;
        par_en  = pe;
        par_odd = po;
        bits = '0;
        bits[8:1] = d;
        nb = 9;
        if (pe) begin
            bits[nb] = (^d) ^ po ^ bad_par;
            nb++;
        end
        bits[nb] = !bad_stop;
        nb++;
        for (int b = 0; b < nb; b++) begin
            for (int t = 0; t < 16; t++) begin
                rx_line = bits[b] ^ ((b == noise_bit) && (t == 8));
                one_tick();
            end
        end
        rx_line = 1'b1;
        for (int k = 0; k < 20; k++) one_tick();
        model_frame(d, noise_bit >= 0, bad_stop, pe && bad_par);
    endtask

    task automatic check_flags(input string req);
        check(req, {27'd0, data_full, overrun, noise_err, frame_err, parity_err},
              {27'd0, m_full, m_or, m_nf, m_fe, m_pf});
    endtask

    task automatic rd_status(input string req);
        @(negedge clk);
        rd_stb = 1'b1;
        rd_addr = 1'b0;
        #1 check(req, {24'd0, rd_data}, {24'd0, exp_status()});
        @(negedge clk) rd_stb = 1'b0;
        m_arm = {m_or, m_nf, m_fe, m_pf};
    endtask

    task automatic rd_data_reg(input string req);
        @(negedge clk);
        rd_stb = 1'b1;
        rd_addr = 1'b1;
        #1 check(req, {24'd0, rd_data}, {24'd0, m_data});
        @(negedge clk) rd_stb = 1'b0;
        if (m_arm[3]) m_or = 1'b0;
        if (m_arm[2]) m_nf = 1'b0;
        if (m_arm[1]) m_fe = 1'b0;
        if (m_arm[0]) m_pf = 1'b0;
        m_full = 1'b0;
        m_arm = '0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state and unused status bits
        check_flags("R11 reset flags");
        rd_status("R11 reset status");

        // R1, R8: plain frame, no parity
        send_frame(8'hA5, 0, 0, 0, 0, -1);
        check_flags("R1 full after frame");
        rd_status("R1 status shows full");
        rd_data_reg("R1 byte value");
        check_flags("R8 data read clears full");

        // R6: even parity good, odd parity bad; R7: lone data read keeps flag
        send_frame(8'h3C, 1, 0, 0, 0, -1);
        check_flags("R6 even parity good");
        rd_data_reg("R1 byte 3C");
        send_frame(8'h81, 1, 1, 1, 0, -1);
        check_flags("R6 odd parity bad sets flag");
        rd_data_reg("R7 data read without status read");
        check_flags("R7 parity flag survives lone data read");
        rd_status("R7 arm parity");
        rd_data_reg("R7 clear parity");
        check_flags("R7 parity cleared");

        // R10: noise on data bit 3
        send_frame(8'h5A, 0, 0, 0, 0, 4);
        check_flags("R10 noise flag");
        rd_status("R10 status noise");
        rd_data_reg("R10 majority byte");
        check_flags("R10 noise cleared");

        // R2, R9: overrun after arming status read
        send_frame(8'h11, 1, 0, 0, 0, -1);
        rd_status("R9 arm status");
        send_frame(8'h22, 1, 0, 1, 0, 2);
        check_flags("R2 overrun set, no error flags from lost frame");
        rd_data_reg("R2 unread byte kept");
        check_flags("R9 overrun still set with full clear");
        rd_status("R9 status overrun without full");
        rd_data_reg("R9 dummy data read");
        check_flags("R9 overrun cleared");

        // R4, R5: framing error halts reception
        send_frame(8'hC3, 0, 0, 0, 1, -1);
        check_flags("R4 framing flag");
        send_frame(8'h77, 0, 0, 0, 0, -1);
        check_flags("R5 frame ignored while halted");
        rd_status("R5 status during halt");
        rd_data_reg("R5 held byte unchanged");
        check_flags("R4 framing cleared");
        send_frame(8'h77, 0, 0, 0, 0, -1);
        check_flags("R5 reception resumes");
        rd_status("R5 status after resume");
        rd_data_reg("R5 byte after resume");

        // random frames and random read orders
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d;
            logic pe, po, bp, bs;
            int nz, nrd;
            d  = 8'($urandom);
            pe = 1'($urandom);
            po = 1'($urandom);
            bp = ($urandom_range(0, 5) == 0);
            bs = ($urandom_range(0, 9) == 0);
            nz = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 9) : -1;
            send_frame(d, pe, po, bp, bs, nz);
            check_flags("R3 random frame flags");
            nrd = $urandom_range(0, 3);
            for (int r = 0; r < nrd; r++) begin
                if ($urandom_range(0, 1) == 0) rd_status("R7 random status read");
                else rd_data_reg("R8 random data read");
            end
            check_flags("R7 random after reads");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule